// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one read or write request into the list of column addresses that a double-data-rate burst visits. A one-cycle start pulse carries the starting column and the low four bits of the mode word: the burst-length code and the ordering bit. From the next clock the block gives two column addresses per cycle, one for each data beat of that clock. A burst of L beats therefore lasts L/2 cycles. A valid flag marks the active cycles, and a last flag marks the final pair.

The burst stays inside an aligned block of L columns. Sequential ordering counts upward from the start offset and wraps at the block edge. Interleaved ordering XORs the beat index into the start offset. The column bits above the block are never changed. A reserved length code raises an error pulse and the request is dropped. A valid start that arrives while a burst is running cuts that burst off, and the new one begins on the next cycle.

Top module: `ddr_burst_colseq`

## Requirements
- R1: After reset, `beat_vld_o`, `last_o` and `err_o` are low.
- R2: Mode bits 2:0 set the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8. Each burst gives `beat_vld_o` high for exactly L/2 consecutive cycles, starting in the cycle after the clock edge that registers `start_i`.
- R3: `last_o` is high only in the final valid cycle of a burst. If no new start arrives, `beat_vld_o` is low in the cycle after it.
- R4: When mode bit 3 is 0 (sequential), beat k has offset (s+k) mod L inside the block, where s is the start column mod L. In cycle j, `col_even_o` carries beat 2j and `col_odd_o` carries beat 2j+1.
- R5: When mode bit 3 is 1 (interleaved), beat k has offset s XOR k, with the same lane placement as R4.
- R6: The column bits at and above bit log2(L) are taken unchanged from the start column in every beat. A wrap never carries into them.
- R7: A start with a reserved length code (3'b000, 3'b100 to 3'b111) raises `err_o` for exactly the next cycle. The request is ignored: a burst in progress keeps its sequence, and an idle block stays idle.
- R8: A valid start during a burst aborts it. The next cycle shows beat pair 0 of the new burst, and this includes a start in the last cycle of the previous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle burst request |
| col_i | input | COL_W | Starting column address |
| mode_i | input | 4 | Mode word bits 3:0: length code in 2:0, ordering in 3 |
| beat_vld_o | output | 1 | A beat pair is presented this cycle |
| last_o | output | 1 | Final beat pair of the burst |
| err_o | output | 1 | The previous start carried a reserved length code |
| col_even_o | output | COL_W | Column for the first beat of the clock |
| col_odd_o | output | COL_W | Column for the second beat of the clock |

## Verification
Each length is run in both orderings with non-zero start offsets. This separates a true wrap inside the block from a plain upward count, and it separates the XOR pattern from the sequential one. Start column 0x1FF with length 8 shows whether a wrap carries into the block bits. Reserved codes are sent both when the block is idle and during a burst, to show that they are rejected without disturbing the burst. Starts in the middle of a burst and in its last cycle check that the old tail is dropped and that there is no dead cycle between bursts.

// File: rtl/ddr_bcs_pkg.sv
package ddr_bcs_pkg;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

  // low-bit mask of an aligned block of 2**lg columns (lg in 1..3)
  function automatic logic [2:0] block_mask(input logic [1:0] lg);
    return ~(3'b111 << lg);
  endfunction

  // offset inside the block for beat k when the burst starts at offset s
  function automatic logic [2:0] lane_offset(input logic [2:0] s, input logic [2:0] k,
                                             input logic [1:0] lg, input order_e ord);
    logic [2:0] raw;
    raw = (ord == ORD_ILV) ? (s ^ k) : (s + k);
    return raw & block_mask(lg);
  endfunction

endpackage

// File: rtl/ddr_bcs_mode_dec.sv
module ddr_bcs_mode_dec
  import ddr_bcs_pkg::*;
(
  input  logic [3:0] mode_i,
  output logic [1:0] lg_o,
  output order_e     ord_o,
  output logic       rsvd_o
);
  always_comb begin
    rsvd_o = 1'b0;
    unique case (mode_i[2:0])
      3'b001:  lg_o = 2'd1;
      3'b010:  lg_o = 2'd2;
      3'b011:  lg_o = 2'd3;
      default: begin lg_o = 2'd0; rsvd_o = 1'b1; end
    endcase
  end
  assign ord_o = order_e'(mode_i[3]);
endmodule

// File: rtl/ddr_bcs_beat_ctr.sv
module ddr_bcs_beat_ctr #(
  parameter int unsigned PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [1:0]        lg_i,
  output logic              active_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              last_o
);
  logic [PAIR_W-1:0] lim_q;
  logic [PAIR_W-1:0] lim_d;

  always_comb begin
    unique case (lg_i)
      2'd2:    lim_d = PAIR_W'(1);
      2'd3:    lim_d = PAIR_W'(3);
      default: lim_d = '0;
    endcase
  end

  assign last_o = active_o && (pair_o == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      pair_o   <= '0;
      lim_q    <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      pair_o   <= '0;
      lim_q    <= lim_d;
    end else if (active_o) begin
      if (last_o) active_o <= 1'b0;
      else        pair_o   <= pair_o + PAIR_W'(1);
    end
  end
endmodule

// File: rtl/ddr_bcs_lane_addr.sv
module ddr_bcs_lane_addr
  import ddr_bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9,
  parameter bit          LANE  = 1'b0
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       pair_i,
  input  logic [1:0]       lg_i,
  input  order_e           ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [2:0] beat;
  logic [2:0] ofs;
  logic [2:0] msk;

  assign beat  = {pair_i, LANE};
  assign msk   = block_mask(lg_i);
  assign ofs   = lane_offset(col_i[2:0], beat, lg_i, ord_i);
  assign col_o = {col_i[COL_W-1:3], (col_i[2:0] & ~msk) | ofs};
endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
  import ddr_bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [3:0]       mode_i,
  output logic             beat_vld_o,
  output logic             last_o,
  output logic             err_o,
  output logic [COL_W-1:0] col_even_o,
  output logic [COL_W-1:0] col_odd_o
);
  localparam int unsigned LANES = 2;

  logic [1:0]       bl_lg;
  order_e           bl_ord;
  logic             bl_rsvd;
  logic             accept;
  logic [COL_W-1:0] col_q;
  logic [1:0]       lg_q;
  order_e           ord_q;
  logic [1:0]       pair;
  logic [COL_W-1:0] lane_col [LANES];

  ddr_bcs_mode_dec u_dec (
    .mode_i (mode_i),
    .lg_o   (bl_lg),
    .ord_o  (bl_ord),
    .rsvd_o (bl_rsvd)
  );

  assign accept = start_i & ~bl_rsvd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      lg_q  <= 2'd1;
      ord_q <= ORD_SEQ;
      err_o <= 1'b0;
    end else begin
      err_o <= start_i & bl_rsvd;
      if (accept) begin
        col_q <= col_i;
        lg_q  <= bl_lg;
        ord_q <= bl_ord;
      end
    end
  end

  ddr_bcs_beat_ctr #(.PAIR_W(2)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .lg_i     (bl_lg),
    .active_o (beat_vld_o),
    .pair_o   (pair),
    .last_o   (last_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_bcs_lane_addr #(.COL_W(COL_W), .LANE(g[0])) u_lane (
      .col_i  (col_q),
      .pair_i (pair),
      .lg_i   (lg_q),
      .ord_i  (ord_q),
      .col_o  (lane_col[g])
    );
  end

  assign col_even_o = lane_col[0];
  assign col_odd_o  = lane_col[1];
endmodule

// File: rtl/ddr_burst_colseq_chk.sv
module ddr_burst_colseq_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             bl_rsvd,
  input logic             beat_vld_o,
  input logic             last_o,
  input logic             err_o,
  input logic [COL_W-1:0] col_even_o,
  input logic [COL_W-1:0] col_odd_o
);
  wire run_on = beat_vld_o && !last_o && !start_i;

  assert_burst_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_on |=> beat_vld_o);

  assert_ends_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && last_o && !start_i) |=> !beat_vld_o);

  assert_lanes_same_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o |-> (col_even_o[COL_W-1:3] == col_odd_o[COL_W-1:3]));

  assert_block_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_on |=> (col_even_o[COL_W-1:3] == $past(col_even_o[COL_W-1:3])));

  assert_err_on_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && bl_rsvd) |=> err_o);

  assert_err_only_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !err_o);

  assert_restart_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !bl_rsvd) |=> (beat_vld_o && !err_o));
endmodule

bind ddr_burst_colseq ddr_burst_colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .bl_rsvd    (bl_rsvd),
  .beat_vld_o (beat_vld_o),
  .last_o     (last_o),
  .err_o      (err_o),
  .col_even_o (col_even_o),
  .col_odd_o  (col_odd_o)
);

// File: tb/ddr_burst_colseq_test.sv
module ddr_burst_colseq_test;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [3:0]       mode_i = '0;
  logic             beat_vld_o, last_o, err_o;
  logic [COL_W-1:0] col_even_o, col_odd_o;

  ddr_burst_colseq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i), .mode_i(mode_i),
    .beat_vld_o(beat_vld_o), .last_o(last_o), .err_o(err_o),
    .col_even_o(col_even_o), .col_odd_o(col_odd_o)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [COL_W-1:0] a;
    logic [COL_W-1:0] b;
    logic             last;
  } item_t;

  item_t q[$];
  int    errs = 0;
  int    checks = 0;
  string tag = "R4";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_col(input int c, input int len, input int k, input bit ilv);
    int s, base;
    s    = c % len;
    base = c - s;
    return ilv ? base + (s ^ k) : base + ((s + k) % len);
  endfunction

  // monitor: pops one expected pair per valid cycle
  always @(negedge clk) begin
    if (rst_n && beat_vld_o) begin
      if (q.size() == 0) begin
        chk(1'b0, tag, "unexpected beat", int'(col_even_o), 0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(col_even_o == e.a, tag, "even lane col", int'(col_even_o), int'(e.a));
        chk(col_odd_o == e.b, tag, "odd lane col", int'(col_odd_o), int'(e.b));
        chk(last_o == e.last, "R3", "last flag", int'(last_o), int'(e.last));
      end
    end
  end

  // driver: registers one start and queues what must come out
  task automatic issue(input int c, input logic [3:0] mode, input string t);
    int len;
    @(posedge clk); #1;
    start_i = 1'b1; col_i = COL_W'(c); mode_i = mode;
    @(posedge clk); #1;
    start_i = 1'b0;
    tag = t;
    len = len_of(mode[2:0]);
    if (len != 0) begin
      q.delete();
      for (int k = 0; k < len; k += 2) begin
        item_t it;
        it.a    = COL_W'(exp_col(c, len, k, mode[3]));
        it.b    = COL_W'(exp_col(c, len, k + 1, mode[3]));
        it.last = (k == len - 2);
        q.push_back(it);
      end
      @(negedge clk);
      chk(err_o == 1'b0, "R7", "err on valid start", int'(err_o), 0);
      chk(beat_vld_o == 1'b1, "R2", "valid after start", int'(beat_vld_o), 1);
    end else begin
      @(negedge clk);
      chk(err_o == 1'b1, "R7", "err on reserved code", int'(err_o), 1);
      @(negedge clk);
      chk(err_o == 1'b0, "R7", "err lasts one cycle", int'(err_o), 0);
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 20; n++) begin
      @(posedge clk);
      if (q.size() == 0) break;
    end
    @(negedge clk);
    chk(q.size() == 0, "R2", "beats missing", q.size(), 0);
    chk(beat_vld_o == 1'b0, "R3", "valid after last", int'(beat_vld_o), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(beat_vld_o == 0, "R1", "reset valid", int'(beat_vld_o), 0);
    chk(last_o == 0, "R1", "reset last", int'(last_o), 0);
    chk(err_o == 0, "R1", "reset err", int'(err_o), 0);
    rst_n = 1'b1;

    issue(9'h0A1, 4'b0001, "R2"); drain();   // length 2 sequential
    issue(9'h00E, 4'b0010, "R4"); drain();   // 2-3-0-1
    issue(9'h015, 4'b0011, "R4"); drain();   // 5-6-7-0-1-2-3-4
    issue(9'h015, 4'b1011, "R5"); drain();   // 5-4-7-6-1-0-3-2
    issue(9'h107, 4'b1010, "R5"); drain();
    issue(9'h0F3, 4'b1001, "R5"); drain();
    issue(9'h1FF, 4'b0011, "R6"); drain();   // wrap stays in block 0x1F8
    issue(9'h1FD, 4'b1011, "R6"); drain();

    // reserved code while idle: nothing starts
    issue(9'h033, 4'b0000, "R7");
    chk(beat_vld_o == 0, "R7", "idle after reserved", int'(beat_vld_o), 0);
    issue(9'h033, 4'b1110, "R7");
    chk(beat_vld_o == 0, "R7", "idle after reserved", int'(beat_vld_o), 0);

    // reserved code during a burst: burst keeps its sequence
    issue(9'h043, 4'b0011, "R7");
    issue(9'h1AA, 4'b0111, "R7");
    drain();

    // restart in the middle of a burst
    issue(9'h022, 4'b0011, "R8");
    issue(9'h1D1, 4'b1010, "R8");
    drain();

    // start landing on the last cycle of a length-4 burst
    issue(9'h0C6, 4'b0010, "R8");
    issue(9'h0B3, 4'b0011, "R8");
    drain();

    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule